// File: doc/BRIEF.md
# Indirect-Read Register Access Bridge

This block connects a 32-bit system request bus to the 16-bit register file of a slower USB device core. Writes to the core window are passed straight on to the addressed core register. Reads go through two steps. Software first writes the wanted register index into a read-request register. It then waits for the completion interrupt, or polls a busy bit. Finally it fetches the result from a read-value register. Every core access, read or write, takes a fixed number of core cycles. When the access finishes, a one-cycle completion interrupt fires.

The bridge enforces three access rules. Only full-word accesses reach the core, except lower-byte writes into the endpoint FIFO window. A second core access is refused while one is running. While the PHY is suspended, every access to the core is refused. A refused request gets an error response and changes no state.

The core is modelled by a register-array stub with a parameter for its latency. The request side is a valid/ready channel whose `req_ready` is always high. A request is taken on any clock edge where `req_valid` is high. The response channel has no back-pressure: `rsp_valid` pulses for exactly one cycle, and the requester must take it.

Top module: `ireg_bridge`

## Requirements
- R1: Every response carries zero in `rsp_rdata[31:16]`. Core register data travels on bits 15:0.
- R2: A word write to byte address 0x200 + 4*i (0x200 to 0x3FC) writes core register i. `done_irq` is high for exactly one cycle, LAT cycles after the response cycle (LAT defaults to 4).
- R3: Writing index i into bits 6:0 at address 0x000 starts a core read. After `done_irq`, a word read of address 0x004 returns register i in bits 15:0.
- R4: A read of 0x000 returns the busy flag in bit 15 and the last requested index in bits 6:0. Busy is 1 from the request until the cycle in which `done_irq` pulses.
- R5: `req_byte`=1 selects a byte access. A byte access is an error except in two cases: a write to core indices 0x20 to 0x27 (the FIFO window), or a read of 0x004. A FIFO byte write replaces only bits 7:0 of the register. A refused byte write leaves the register unchanged and raises no interrupt.
- R6: A byte read of 0x004 returns the read value's bits 7:0, with bits 31:8 zero.
- R7: While `phy_suspend` is 1, any core-window access and any write to 0x000 gets an error response. No core access starts, no interrupt fires and no register changes.
- R8: A core write or a read request taken while an access is busy gets an error response. It does not disturb the running access.
- R9: Indices 64 to 127 have no register behind them, but requests for them are still forwarded to the core. They complete with `done_irq` after LAT cycles. Writes to them have no effect, and reads load an unspecified value.
- R10: Each accepted request gets exactly one response in the next cycle, and `req_ready` is always 1. A direct read of the core window returns zero, without error and without starting a core access.
- R11: After reset, `rsp_valid` and `done_irq` are low, the busy flag is 0 and the read value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_suspend | input | 1 | PHY suspended; core accesses are refused |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = lower-byte access, 0 = word |
| req_addr | input | 10 | Byte address within the bridge |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
A response is due one cycle after acceptance. The bench drives each request on a falling edge and samples the response on the next falling edge. The completion interrupt is due LAT cycles after the response. The bench counts falling edges from the response to the interrupt and requires the count to be exactly LAT. For refused requests it watches for LAT+2 cycles to confirm that no interrupt comes. Read results are compared against a register model kept in the bench. The busy bit is sampled once while the access is still running and again after the interrupt.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  typedef enum logic [1:0] {
    RG_RDREQ = 2'd0,
    RG_RVAL  = 2'd1,
    RG_CORE  = 2'd2,
    RG_OTHER = 2'd3
  } region_t;
endpackage

// File: rtl/ireg_decode.sv
module ireg_decode
  import ireg_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int FIFO_BASE = 32,
  parameter int FIFO_NUM  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              bsz,
  input  logic              suspend,
  input  logic              busy,
  output region_t           region,
  output logic [ADDR_W-4:0] idx,
  output logic              err,
  output logic              start,
  output logic              start_rd
);
  localparam int CIDX_W = ADDR_W - 3;
  localparam logic [CIDX_W-1:0] FLO = CIDX_W'(FIFO_BASE);
  localparam logic [CIDX_W-1:0] FHI = CIDX_W'(FIFO_BASE + FIFO_NUM);

  logic is_fifo, byte_ok, starts_op;
  logic unused_lo;
  assign unused_lo = ^addr[1:0];

  assign idx = addr[ADDR_W-2:2];

  always_comb begin
    if (addr[ADDR_W-1])                region = RG_CORE;
    else if (addr[ADDR_W-2:2] == '0)   region = RG_RDREQ;
    else if (addr[ADDR_W-2:2] == 'd1)  region = RG_RVAL;
    else                               region = RG_OTHER;
  end

  assign is_fifo   = (idx >= FLO) && (idx < FHI);
  assign byte_ok   = (region == RG_CORE && wr && is_fifo) || (region == RG_RVAL && !wr);
  assign starts_op = wr && (region == RG_CORE || region == RG_RDREQ);

  assign err = (bsz && !byte_ok)
             || (suspend && (region == RG_CORE || starts_op))
             || (busy && starts_op);

  assign start    = starts_op && !err;
  assign start_rd = start && (region == RG_RDREQ);
endmodule

// File: rtl/ireg_core_stub.sv
module ireg_core_stub #(
  parameter int CIDX_W    = 7,
  parameter int IMPL_REGS = 64,
  parameter int LAT       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr,
  input  logic              bsz,
  input  logic [CIDX_W-1:0] idx,
  input  logic [15:0]       wdata,
  output logic              ack,
  output logic [15:0]       rdata
);
  localparam int CW = $clog2(LAT + 1);
  localparam int IW = $clog2(IMPL_REGS);
  localparam logic [CIDX_W:0] IMPL_L = (CIDX_W + 1)'(IMPL_REGS);

  logic [15:0]       mem [IMPL_REGS];
  logic              active, c_wr, c_bsz;
  logic [CW-1:0]     cnt;
  logic [CIDX_W-1:0] c_idx;
  logic [15:0]       c_wd;
  logic              present;
  logic [IW-1:0]     ci;

  assign ci      = c_idx[IW-1:0];
  assign present = {1'b0, c_idx} < IMPL_L;
  assign ack     = active && (cnt == '0);
  assign rdata   = present ? mem[ci] : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      c_wr   <= 1'b0;
      c_bsz  <= 1'b0;
      c_idx  <= '0;
      c_wd   <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(LAT - 1);
      c_wr   <= wr;
      c_bsz  <= bsz;
      c_idx  <= idx;
      c_wd   <= wdata;
    end else if (ack) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < IMPL_REGS; k++) mem[k] <= '0;
    end else if (ack && c_wr && present) begin
      if (c_bsz) mem[ci] <= {mem[ci][15:8], c_wd[7:0]};
      else       mem[ci] <= c_wd;
    end
  end
endmodule

// File: rtl/ireg_seq.sv
module ireg_seq #(
  parameter int CIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [CIDX_W-1:0] idx,
  input  logic              ack,
  input  logic [15:0]       core_rdata,
  output logic              busy,
  output logic [CIDX_W-1:0] req_idx,
  output logic [15:0]       rval,
  output logic              irq
);
  logic rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rd_pend <= 1'b0;
      req_idx <= '0;
      rval    <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= ack;
      if (start) begin
        busy    <= 1'b1;
        rd_pend <= start_rd;
        if (start_rd) req_idx <= idx;
      end else if (ack) begin
        busy    <= 1'b0;
        rd_pend <= 1'b0;
        if (rd_pend) rval <= core_rdata;
      end
    end
  end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int FIFO_BASE = 32,
  parameter int FIFO_NUM  = 8,
  parameter int IMPL_REGS = 64,
  parameter int LAT       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_suspend,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              done_irq
);
  localparam int CIDX_W = ADDR_W - 3;

  region_t           region;
  logic [CIDX_W-1:0] dec_idx, core_idx, req_idx;
  logic              dec_err, dec_start, dec_start_rd;
  logic              core_start, core_ack, busy;
  logic [15:0]       core_rdata, rval, rq_word, rd_mux16;
  logic              unused_hi;

  assign unused_hi = ^req_wdata[31:16];
  assign req_ready = 1'b1;

  ireg_decode #(.ADDR_W(ADDR_W), .FIFO_BASE(FIFO_BASE), .FIFO_NUM(FIFO_NUM)) u_dec (
    .addr(req_addr), .wr(req_write), .bsz(req_byte), .suspend(phy_suspend), .busy(busy),
    .region(region), .idx(dec_idx), .err(dec_err), .start(dec_start), .start_rd(dec_start_rd)
  );

  assign core_start = req_valid && dec_start;
  assign core_idx   = dec_start_rd ? req_wdata[CIDX_W-1:0] : dec_idx;

  ireg_core_stub #(.CIDX_W(CIDX_W), .IMPL_REGS(IMPL_REGS), .LAT(LAT)) u_core (
    .clk(clk), .rst_n(rst_n), .start(core_start), .wr(!dec_start_rd), .bsz(req_byte),
    .idx(core_idx), .wdata(req_wdata[15:0]), .ack(core_ack), .rdata(core_rdata)
  );

  ireg_seq #(.CIDX_W(CIDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(core_start), .start_rd(req_valid && dec_start_rd),
    .idx(req_wdata[CIDX_W-1:0]), .ack(core_ack), .core_rdata(core_rdata),
    .busy(busy), .req_idx(req_idx), .rval(rval), .irq(done_irq)
  );

  always_comb begin
    rq_word             = '0;
    rq_word[15]         = busy;
    rq_word[CIDX_W-1:0] = req_idx;
    case (region)
      RG_RDREQ: rd_mux16 = rq_word;
      RG_RVAL:  rd_mux16 = req_byte ? {8'h00, rval[7:0]} : rval;
      default:  rd_mux16 = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec_err;
      rsp_rdata <= (req_valid && !req_write && !dec_err) ? {16'h0000, rd_mux16} : 32'h0;
    end
  end
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phy_suspend,
  input logic        req_valid,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic        done_irq,
  input logic        core_start,
  input logic        core_ack,
  input logic        busy,
  input logic [15:0] rval
);
  a_r10_err_has_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[31:16] == 16'h0000));
  a_r7_suspend_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && phy_suspend) |-> !core_start);
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !busy);
  a_r2_irq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack |=> done_irq);
  a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  a_r3_rval_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ack |=> $stable(rval));
  a_r4_busy_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_ack) |=> busy);
endmodule

bind ireg_bridge ireg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phy_suspend(phy_suspend), .req_valid(req_valid),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .done_irq(done_irq), .core_start(core_start), .core_ack(core_ack), .busy(busy), .rval(rval)
);

// File: tb/ireg_bridge_tb.sv
module ireg_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam int NV = 12;
  // {kind, index, data}: kind 0 word write, 1 FIFO byte write, 2 indirect read
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 7'd3,  16'hA5C3}, {2'd0, 7'd10, 16'h1234}, {2'd2, 7'd3,  16'h0000},
    {2'd2, 7'd10, 16'h0000}, {2'd0, 7'd63, 16'hFFFF}, {2'd2, 7'd63, 16'h0000},
    {2'd0, 7'd33, 16'hBEEF}, {2'd1, 7'd33, 16'h9977}, {2'd2, 7'd33, 16'h0000},
    {2'd2, 7'd0,  16'h0000}, {2'd1, 7'd32, 16'h125A}, {2'd2, 7'd32, 16'h0000}
  };

  logic clk = 0, rst_n = 0, phy_suspend = 0;
  logic req_valid = 0, req_write = 0, req_byte = 0;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, done_irq;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_fail = 0;
  logic finished = 0;
  logic [15:0] model [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  ireg_bridge #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .phy_suspend(phy_suspend), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .done_irq(done_irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic bsz, input logic [9:0] a, input logic [31:0] d,
                     output logic err, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_byte = bsz; req_addr = a; req_wdata = d;
    @(negedge clk);
    chk(rsp_valid && req_ready, "R10 response strobe", {31'b0, rsp_valid}, 32'd1);
    err = rsp_err; rd = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!done_irq && n < LAT + 6);
  endtask

  task automatic no_irq(output logic seen);
    seen = 0;
    repeat (LAT + 2) begin @(negedge clk); if (done_irq) seen = 1; end
  endtask

  task automatic ind_read(input logic [6:0] i, output logic [31:0] v);
    logic e; logic [31:0] r; int n;
    acc(1, 0, 10'h000, {25'h0, i}, e, r);
    chk(!e, "R3 request accepted", {31'b0, e}, 32'd0);
    wait_irq(n);
    chk(n == LAT, "R3 read irq latency", n, LAT);
    acc(0, 0, 10'h004, 32'h0, e, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic e, seen; logic [31:0] r, v; int n;
    for (int k = 0; k < 64; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !done_irq, "R11 outputs after reset", {30'b0, rsp_valid, done_irq}, 32'd0);
    rst_n = 1;
    acc(0, 0, 10'h000, 32'h0, e, r);
    chk(r == 32'h0, "R11 busy flag after reset", r, 32'h0);
    acc(0, 0, 10'h004, 32'h0, e, r);
    chk(r == 32'h0, "R11 read value after reset", r, 32'h0);

    for (int j = 0; j < NV; j++) begin
      logic [1:0] kd; logic [6:0] ix; logic [15:0] dt;
      {kd, ix, dt} = VEC[j];
      if (kd == 2'd2) begin
        ind_read(ix, v);
        chk(v == {16'h0, model[ix[5:0]]}, "R3 read value vs model", v, {16'h0, model[ix[5:0]]});
      end else begin
        acc(1, kd == 2'd1, 10'h200 + {1'b0, ix, 2'b00}, {16'hFFFF, dt}, e, r);
        chk(!e, "R2 write accepted", {31'b0, e}, 32'd0);
        wait_irq(n);
        chk(n == LAT, "R2 write irq latency", n, LAT);
        @(negedge clk);
        chk(!done_irq, "R2 irq one cycle", {31'b0, done_irq}, 32'd0);
        if (kd == 2'd1) model[ix[5:0]][7:0] = dt[7:0];
        else            model[ix[5:0]] = dt;
      end
    end

    // R6: byte read of read value (last read was index 32 = 0x005A)
    acc(0, 1, 10'h004, 32'h0, e, r);
    chk(!e && r == 32'h0000005A, "R6 byte read of read value", r, 32'h5A);
    ind_read(7'd3, v);
    acc(0, 1, 10'h004, 32'h0, e, r);
    chk(r == 32'h000000C3, "R6 byte read low bits only", r, 32'hC3);
    chk(v[31:16] == 16'h0, "R1 upper half zero", v, 32'h0000A5C3);

    // R5: byte write outside FIFO window is refused
    acc(1, 1, 10'h200 + 10'd12, 32'h0000_0011, e, r);
    chk(e, "R5 byte write non-FIFO error", {31'b0, e}, 32'd1);
    no_irq(seen);
    chk(!seen, "R5 no irq on refused byte write", {31'b0, seen}, 32'd0);
    ind_read(7'd3, v);
    chk(v == 32'h0000A5C3, "R5 register unchanged", v, 32'h0000A5C3);

    // R7: suspend
    phy_suspend = 1;
    acc(1, 0, 10'h200 + 10'd12, 32'h0000_7777, e, r);
    chk(e, "R7 core write error while suspended", {31'b0, e}, 32'd1);
    acc(1, 0, 10'h000, 32'd10, e, r);
    chk(e, "R7 read request error while suspended", {31'b0, e}, 32'd1);
    acc(0, 0, 10'h004, 32'h0, e, r);
    chk(!e && r == 32'h0000A5C3, "R7 read value still readable", r, 32'h0000A5C3);
    no_irq(seen);
    chk(!seen, "R7 no irq while suspended", {31'b0, seen}, 32'd0);
    phy_suspend = 0;
    ind_read(7'd3, v);
    chk(v == 32'h0000A5C3, "R7 register unchanged after suspend", v, 32'h0000A5C3);

    // R8: second write while busy is refused
    acc(1, 0, 10'h200 + 10'd40, 32'h0000_4444, e, r);
    acc(1, 0, 10'h200 + 10'd40, 32'h0000_5555, e, r);
    chk(e, "R8 write while busy error", {31'b0, e}, 32'd1);
    wait_irq(n);
    chk(n == LAT - 2, "R8 first access irq on time", n, LAT - 2);
    ind_read(7'd10, v);
    chk(v == 32'h00004444, "R8 running write kept", v, 32'h00004444);

    // R4: busy flag and index readback
    acc(1, 0, 10'h000, 32'd10, e, r);
    acc(0, 0, 10'h000, 32'h0, e, r);
    chk(r == 32'h0000800A, "R4 busy flag set during read", r, 32'h0000800A);
    wait_irq(n);
    acc(0, 0, 10'h000, 32'h0, e, r);
    chk(r == 32'h0000000A, "R4 busy flag clear after irq", r, 32'h0000000A);

    // R9: unimplemented index still completes
    acc(1, 0, 10'h200 + 10'd400, 32'h0000_1111, e, r);
    wait_irq(n);
    chk(!e && n == LAT, "R9 unimplemented write completes", n, LAT);
    acc(1, 0, 10'h000, 32'd100, e, r);
    wait_irq(n);
    chk(!e && n == LAT, "R9 unimplemented read completes", n, LAT);

    // R10: direct read of core window
    acc(0, 0, 10'h200 + 10'd12, 32'h0, e, r);
    chk(!e && r == 32'h0, "R10 direct read returns zero", r, 32'h0);
    no_irq(seen);
    chk(!seen, "R10 direct read starts no access", {31'b0, seen}, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule